// File: doc/BRIEF.md
# Cascadable Interrupt Controller

This block collects 32 interrupt request lines into two processor-facing interrupt outputs, one for critical and one for non-critical requests. Each request line has its own configuration bits: an enable, a sensitivity selector (level or edge), an active-polarity selector and a class selector (critical or not). Every line passes through a two-flop synchronizer, is converted to active-high form by its polarity bit, and then sets a sticky status bit. Software reads these status bits back and acknowledges them by writing ones.

Software sees a masked view of the status, which is the status ANDed with the enable register. The block also reports which masked source has the highest priority. Source numbering runs from the most significant bit, so source n occupies bit 31-n, and source 0 has the highest priority.

Two controllers can be chained. The secondary controller's interrupt output is wired to one source line of the primary. The secondary's pending index is fed into the primary's cascade inputs, and whenever that source is the winning one, the primary reports the secondary's index plus 32.

Top module: `irq_hub`

## Requirements
- R1: After reset the status, enable and critical registers read zero, the polarity register reads all ones, and the trigger register reads zero. Both interrupt outputs are low, `pend_valid_o` is 0 and `pend_idx_o` is 127.
- R2: Address 5 reads status AND enable. A write to address 5 changes no register.
- R3: A write to address 0 clears every status bit written as 1 and leaves every bit written as 0 unchanged.
- R4: When a trigger bit is 0 (level), the status bit is set on every clock in which the conditioned input is active. A clear issued while the input is still active therefore leaves the bit set.
- R5: When a trigger bit is 1 (edge), the status bit is set only on an inactive-to-active transition of the conditioned input. After a clear it stays 0 while the input is held active.
- R6: Polarity bit 1 selects active-high or rising detection. Polarity bit 0 selects active-low or falling detection.
- R7: If a clear and a new event reach the same status bit in the same cycle, the bit stays set.
- R8: A change on `src_i` shows in the status register after the third rising clock edge, and not after the second.
- R9: `irq_crit_o` is high exactly when some masked bit has its critical bit at 1. `irq_ncrit_o` is high exactly when some masked bit has its critical bit at 0.
- R10: `pend_idx_o` is the smallest n whose masked bit 31-n is set, with `pend_valid_o` at 1. When no masked bit is set, the index is 127 and `pend_valid_o` is 0.
- R11: When the winning source is CASC_SRC (default 30, bit 1) and `casc_valid_i` is 1, the index is 32 + `casc_idx_i`. When `casc_valid_i` is 0, the index is CASC_SRC.
- R12: The register addresses are: 0 status, 1 enable, 2 critical, 3 polarity, 4 trigger, 5 masked. Addresses 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Asynchronous request lines; source n on bit 31-n |
| reg_addr_i | input | 3 | Register select |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Combinational read data for `reg_addr_i` |
| casc_valid_i | input | 1 | Secondary controller has a pending source |
| casc_idx_i | input | 7 | Secondary controller's pending index |
| irq_ncrit_o | output | 1 | Non-critical interrupt request |
| irq_crit_o | output | 1 | Critical interrupt request |
| pend_valid_o | output | 1 | Some masked source is pending |
| pend_idx_o | output | 7 | Index of the highest-priority pending source, 127 when none |

## Verification
The bench aims at the cases where a design most often goes wrong.

- Acknowledging a level source while its input is still active: a design that lets the clear win would drop a live request.
- Acknowledging an edge source while its input is held: a design that treats the held level as new edges would raise the request again at once.
- Falling-edge detection after a polarity change, and the exact three-edge input latency: a miscounted synchronizer would move the status update by one cycle.
- Two sources pending together, and the cascade source winning with `casc_valid_i` high and low: a priority encoder that scans in the wrong direction, or drops the +32 offset, reports the wrong index.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  typedef enum logic [2:0] {
    RA_STATUS = 3'd0,
    RA_ENABLE = 3'd1,
    RA_CRIT   = 3'd2,
    RA_POL    = 3'd3,
    RA_TRIG   = 3'd4,
    RA_MASKED = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/irq_cond.sv
module irq_cond #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw_i,
  input  logic [N-1:0] pol_i,
  input  logic [N-1:0] trig_i,
  output logic [N-1:0] evt_o
);
  logic [N-1:0] s1_q, s2_q, prev_q, cond_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= raw_i;
      s2_q   <= s1_q;
      prev_q <= cond_w;
    end
  end

  for (genvar b = 0; b < N; b++) begin : g_bit
    assign cond_w[b] = pol_i[b] ? s2_q[b] : ~s2_q[b];
    assign evt_o[b]  = trig_i[b] ? (cond_w[b] & ~prev_q[b]) : cond_w[b];
  end
endmodule

// File: rtl/irq_stat.sv
module irq_stat #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] status_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_o <= '0;
    else        status_o <= (status_o & ~clr_i) | evt_i;
  end
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int N        = 32,
  parameter int IDX_W    = 7,
  parameter int CASC_SRC = 30
) (
  input  logic [N-1:0]     masked_i,
  input  logic             casc_valid_i,
  input  logic [IDX_W-1:0] casc_idx_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] IDX_NONE = '1;

  function automatic logic [IDX_W-1:0] first_src(input logic [N-1:0] m);
    logic [IDX_W-1:0] r;
    r = IDX_NONE;
    for (int n = N - 1; n >= 0; n--) begin
      if (m[N-1-n]) r = IDX_W'(n);
    end
    return r;
  endfunction

  logic [IDX_W-1:0] local_w;

  always_comb begin
    local_w = first_src(masked_i);
    valid_o = |masked_i;
    if (valid_o && local_w == IDX_W'(CASC_SRC) && casc_valid_i)
      idx_o = IDX_W'(N) + casc_idx_i;
    else
      idx_o = local_w;
  end
endmodule

// File: rtl/irq_hub.sv
module irq_hub #(
  parameter int NSRC     = 32,
  parameter int CASC_SRC = 30,
  parameter int AW       = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NSRC-1:0]              src_i,
  input  logic [AW-1:0]                reg_addr_i,
  input  logic                         reg_we_i,
  input  logic [NSRC-1:0]              reg_wdata_i,
  output logic [NSRC-1:0]              reg_rdata_o,
  input  logic                         casc_valid_i,
  input  logic [$clog2(2*NSRC):0]      casc_idx_i,
  output logic                         irq_ncrit_o,
  output logic                         irq_crit_o,
  output logic                         pend_valid_o,
  output logic [$clog2(2*NSRC):0]      pend_idx_o
);
  import irq_hub_pkg::*;
  localparam int IDX_W = $clog2(2*NSRC) + 1;

  logic [NSRC-1:0] enable_q, crit_q, pol_q, trig_q;
  logic [NSRC-1:0] status_q, masked_w, evt_w, clr_w;
  reg_addr_e       addr_w;

  assign addr_w   = reg_addr_e'(reg_addr_i[2:0]);
  assign clr_w    = (reg_we_i && addr_w == RA_STATUS) ? reg_wdata_i : '0;
  assign masked_w = status_q & enable_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
      crit_q   <= '0;
      pol_q    <= '1;
      trig_q   <= '0;
    end else if (reg_we_i) begin
      case (addr_w)
        RA_ENABLE: enable_q <= reg_wdata_i;
        RA_CRIT:   crit_q   <= reg_wdata_i;
        RA_POL:    pol_q    <= reg_wdata_i;
        RA_TRIG:   trig_q   <= reg_wdata_i;
        default:   ;
      endcase
    end
  end

  always_comb begin
    case (addr_w)
      RA_STATUS: reg_rdata_o = status_q;
      RA_ENABLE: reg_rdata_o = enable_q;
      RA_CRIT:   reg_rdata_o = crit_q;
      RA_POL:    reg_rdata_o = pol_q;
      RA_TRIG:   reg_rdata_o = trig_q;
      RA_MASKED: reg_rdata_o = masked_w;
      default:   reg_rdata_o = '0;
    endcase
  end

  irq_cond #(.N(NSRC)) u_cond (
    .clk(clk), .rst_n(rst_n), .raw_i(src_i), .pol_i(pol_q),
    .trig_i(trig_q), .evt_o(evt_w)
  );

  irq_stat #(.N(NSRC)) u_stat (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_w), .clr_i(clr_w),
    .status_o(status_q)
  );

  irq_prio #(.N(NSRC), .IDX_W(IDX_W), .CASC_SRC(CASC_SRC)) u_prio (
    .masked_i(masked_w), .casc_valid_i(casc_valid_i),
    .casc_idx_i(casc_idx_i), .valid_o(pend_valid_o), .idx_o(pend_idx_o)
  );

  assign irq_crit_o  = |(masked_w & crit_q);
  assign irq_ncrit_o = |(masked_w & ~crit_q);
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk #(
  parameter int NSRC  = 32,
  parameter int IDX_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NSRC-1:0]  status_q,
  input logic [NSRC-1:0]  enable_q,
  input logic [NSRC-1:0]  masked_w,
  input logic [NSRC-1:0]  evt_w,
  input logic [NSRC-1:0]  clr_w,
  input logic             irq_crit_o,
  input logic             irq_ncrit_o,
  input logic             pend_valid_o,
  input logic [IDX_W-1:0] pend_idx_o,
  input logic             casc_valid_i
);
  assert_masked_subset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (masked_w & ~enable_q) == '0);

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (status_q & $past(clr_w & ~evt_w)) == '0);

  assert_event_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (status_q & $past(evt_w)) == $past(evt_w));

  assert_quiet_outputs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_valid_o |-> (!irq_crit_o && !irq_ncrit_o));

  assert_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid_o == (masked_w != '0));

  assert_none_idx_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_valid_o |-> pend_idx_o == '1);

  assert_cascade_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_valid_o && pend_idx_o >= IDX_W'(NSRC)) |-> casc_valid_i);
endmodule

bind irq_hub irq_hub_chk #(.NSRC(NSRC), .IDX_W($clog2(2*NSRC) + 1)) u_chk (
  .clk(clk), .rst_n(rst_n), .status_q(status_q), .enable_q(enable_q),
  .masked_w(masked_w), .evt_w(evt_w), .clr_w(clr_w),
  .irq_crit_o(irq_crit_o), .irq_ncrit_o(irq_ncrit_o),
  .pend_valid_o(pend_valid_o), .pend_idx_o(pend_idx_o),
  .casc_valid_i(casc_valid_i)
);

// File: tb/irq_hub_bench.sv
module irq_hub_bench;
  localparam int CLK_P = 10;

  logic        clk = 0, rst_n = 0;
  logic [31:0] src = '0, wdata = '0;
  logic [2:0]  addr = '0;
  logic        we = 0, cv = 0;
  logic [6:0]  ci = '0;
  logic [31:0] rdata;
  logic        ncrit, crit, pv;
  logic [6:0]  pidx;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  irq_hub u_irq_hub (
    .clk(clk), .rst_n(rst_n), .src_i(src), .reg_addr_i(addr), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .casc_valid_i(cv), .casc_idx_i(ci),
    .irq_ncrit_o(ncrit), .irq_crit_o(crit), .pend_valid_o(pv), .pend_idx_o(pidx)
  );

  always #(CLK_P/2) clk = ~clk;

  // behavioural reference model
  logic [31:0] m_en, m_cr, m_pol, m_tr, m_st, m_s1, m_s2, m_prev;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_cr = 0; m_pol = '1; m_tr = 0; m_st = 0;
      m_s1 = 0; m_s2 = 0; m_prev = 0;
    end else begin
      logic [31:0] act, nxt_st;
      act = 0;
      for (int b = 0; b < 32; b++) begin
        bit a;
        a = (m_s2[b] == m_pol[b]);
        if (m_tr[b]) act[b] = a && !m_prev[b];
        else         act[b] = a;
        m_prev[b] = a;
      end
      nxt_st = m_st;
      if (we && addr == 0) nxt_st = nxt_st & ~wdata;
      m_st = nxt_st | act;
      if (we) begin
        case (addr)
          3'd1: m_en  = wdata;
          3'd2: m_cr  = wdata;
          3'd3: m_pol = wdata;
          3'd4: m_tr  = wdata;
          default: ;
        endcase
      end
      m_s2 = m_s1;
      m_s1 = src;
    end
  end

  function automatic int ref_idx(logic [31:0] m, logic v, logic [6:0] c);
    for (int n = 0; n < 32; n++)
      if (m[31-n]) return (n == 30 && v) ? 32 + int'(c) : n;
    return 127;
  endfunction

  function automatic logic [31:0] ref_read(logic [2:0] a);
    case (a)
      3'd0: return m_st;
      3'd1: return m_en;
      3'd2: return m_cr;
      3'd3: return m_pol;
      3'd4: return m_tr;
      3'd5: return m_st & m_en;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      logic [31:0] mk;
      mk = m_st & m_en;
      chk("R12 rdata", rdata, ref_read(addr));
      chk("R9 crit", {31'd0, crit}, {31'd0, |(mk & m_cr)});
      chk("R9 ncrit", {31'd0, ncrit}, {31'd0, |(mk & ~m_cr)});
      chk("R10 valid", {31'd0, pv}, {31'd0, mk != 0});
      chk("R10_R11 idx", {25'd0, pidx}, ref_idx(mk, cv, ci));
    end
  end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1;
    @(negedge clk); we = 0; addr = 0;
  endtask

  task automatic rd(logic [2:0] a, logic [31:0] exp, string tag);
    @(negedge clk); addr = a; #1;
    chk(tag, rdata, exp);
    addr = 0;
  endtask

  task automatic settle(int k);
    repeat (k) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(0, 32'h0, "R1 status"); rd(1, 32'h0, "R1 enable"); rd(2, 32'h0, "R1 crit");
    rd(3, 32'hFFFF_FFFF, "R1 pol"); rd(4, 32'h0, "R1 trig");
    chk("R1 idx", {25'd0, pidx}, 127); chk("R1 irq", {30'd0, crit, ncrit}, 0);
    // R12 unused addresses
    rd(6, 0, "R12 addr6"); rd(7, 0, "R12 addr7");

    wr(1, 32'hFFFF_FFFF);
    // R8 latency, source 3 = bit 28, level
    @(negedge clk); src[28] = 1;
    @(negedge clk);
    @(negedge clk); #1; chk("R8 not after 2 edges", rdata, 0);
    @(negedge clk); #1; chk("R8 after 3 edges", rdata, 32'h1000_0000);
    chk("R10 idx source3", {25'd0, pidx}, 3);
    // R4/R7 clear while level active keeps bit
    wr(0, 32'h1000_0000);
    rd(0, 32'h1000_0000, "R4_R7 level stays set");
    src[28] = 0; settle(4);
    wr(0, 32'h1000_0000);
    rd(0, 0, "R3 cleared after input drop");

    // R5 edge
    wr(4, 32'h1000_0000);
    @(negedge clk); src[28] = 1; settle(4);
    rd(0, 32'h1000_0000, "R5 edge captured");
    wr(0, 32'h1000_0000); settle(3);
    rd(0, 0, "R5 edge stays clear while held");
    // R6 falling edge
    wr(3, 32'hEFFF_FFFF); settle(3);
    rd(0, 0, "R6 no event on polarity flip");
    @(negedge clk); src[28] = 0; settle(4);
    rd(0, 32'h1000_0000, "R6 falling edge captured");
    wr(3, 32'hFFFF_FFFF); wr(4, 0); wr(0, 32'hFFFF_FFFF);
    rd(0, 0, "R3 clear all");

    // priority and class: sources 5 (bit 26) and 10 (bit 21)
    @(negedge clk); src[26] = 1; src[21] = 1; settle(4);
    chk("R10 idx 5 wins", {25'd0, pidx}, 5);
    chk("R9 only ncrit", {30'd0, crit, ncrit}, 1);
    wr(2, 32'h0400_0000); #3;
    chk("R9 both", {30'd0, crit, ncrit}, 3);
    wr(5, 32'h0);
    rd(5, 32'h0420_0000, "R2 masked read-only");
    wr(1, 32'hFBFF_FFFF); #3;
    chk("R2 idx after mask", {25'd0, pidx}, 10);
    chk("R9 crit masked off", {30'd0, crit, ncrit}, 1);
    rd(0, 32'h0420_0000, "R2 status keeps masked bit");
    // R3 single-bit ack leaves other bits
    src[26] = 0; src[21] = 0; settle(4);
    wr(0, 32'h0400_0000);
    rd(0, 32'h0020_0000, "R3 single bit ack");
    wr(0, 32'hFFFF_FFFF); wr(1, 32'hFFFF_FFFF); wr(2, 0);

    // R11 cascade, source 30 = bit 1, source 31 = bit 0
    @(negedge clk); src[1] = 1; src[0] = 1; settle(4);
    chk("R11 idx no cascade valid", {25'd0, pidx}, 30);
    @(negedge clk); cv = 1; ci = 7'd7; #3;
    chk("R11 cascade offset", {25'd0, pidx}, 39);
    @(negedge clk); ci = 7'd31; #3;
    chk("R11 cascade offset max", {25'd0, pidx}, 63);
    src = 0; settle(4); wr(0, 32'hFFFF_FFFF);
    @(negedge clk); #3;
    chk("R10 none", {25'd0, pidx}, 127);
    cv = 0;
    settle(2);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule